// File: doc/BRIEF.md
# Toeplitz Receive Hash and Queue Selector

This block computes a 32-bit Toeplitz hash over a flow tuple and picks a receive queue for it. The tuple enters one byte per cycle on a valid/last stream: source IPv4 address, destination IPv4 address, source port, then destination port, each sent most-significant byte first, 12 bytes in all. One cycle after the byte marked last, the block presents the hash, the chosen queue ID and a one-cycle done strobe.

A 40-byte secret key and an indirection table of up to 16 queue IDs are held in registers and programmed through a byte-wide write port. The queue is read from the table entry indexed by the low bits of the hash, not taken as the hash modulo the queue count. The table is 16 or 8 entries long, chosen by a run-time register. The key, the table and the table size are captured when a tuple starts, so a write made while a tuple is in flight changes only the tuples that start after it. Extracting the tuple from a packet is left to the logic upstream. The hash is not symmetric: swapping source and destination does not, in general, give the same hash.

Top module: `rss_hash_top`

## Requirements
- R1: After reset, done_o, hash_o and queue_o are 0. The key holds the 40-byte default 6d5a56da255b0ec24167253d43a38fb0d0ca2bcbae7b30b477cb2da38030f20c6a42b73bbeac01fa, with byte 0 first. The table is in 16-entry mode and entry i holds i mod 4.
- R2: The hash is the Toeplitz hash of the tuple bytes. Bit i of the input stream is counted from the MSB of the first byte. When that bit is 1, the hash is XORed with key bits i to i+31, where key bit 0 is the MSB of key byte 0. The same tuple always gives the same hash and queue.
- R3: done_o is high for exactly the one cycle after an accepted byte with in_last_i high. hash_o and queue_o change only in that cycle and hold until the next done.
- R4: Cycles with in_valid_i low inside a tuple do not change the result.
- R5: The byte after a last byte starts a new tuple with a cleared accumulator. This holds with no idle cycle between tuples, and a one-byte tuple (first and last together) is hashed correctly.
- R6: In 16-entry mode, queue_o is table entry hash[3:0]. In 8-entry mode, it is entry {0, hash[2:0]}.
- R7: A write with cfg_sel_i = 0 stores cfg_wdata_i into key byte cfg_addr_i (0 to 39).
- R8: A write with cfg_sel_i = 1 stores cfg_wdata_i[QID_W-1:0] into table entry cfg_addr_i (0 to 15). A write with cfg_sel_i = 2 sets the table size: wdata bit 0 = 1 selects 16 entries, 0 selects 8.
- R9: Key, table and size writes made after the first byte of a tuple is accepted do not affect that tuple's hash or queue. They apply from the next tuple on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Tuple byte valid |
| in_data_i | input | 8 | Tuple byte |
| in_last_i | input | 1 | Marks the final byte of a tuple |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 key, 1 table, 2 table size |
| cfg_addr_i | input | 6 | Key byte index or table entry index |
| cfg_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-cycle strobe: result valid |
| hash_o | output | 32 | Toeplitz hash of the last tuple |
| queue_o | output | QID_W | Selected queue ID |

## Verification
The hardest situation to reach is a configuration write that lands while a tuple is half consumed. To prove the in-flight tuple still uses the old key and table, the write must be timed to a specific mid-tuple byte, and the following tuple must then show the new values. The bench drives the key and table writes in the same cycle as the fifth tuple byte. It compares that tuple against a model that still uses the old settings, then sends the next tuple against the updated model. The same stimulus also runs back-to-back tuples with no idle cycle, and a one-byte tuple whose first byte is also its last, so that the live configuration path is used directly.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int KEY_BYTES = 40;
  localparam int KEY_W     = KEY_BYTES * 8;
  localparam int HASH_W    = 32;
  localparam int ADDR_W    = 6;

  typedef enum logic [1:0] {
    CFG_KEY  = 2'd0,
    CFG_TBL  = 2'd1,
    CFG_SIZE = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;

  localparam logic [KEY_W-1:0] DEFAULT_KEY =
    320'h6d5a56da255b0ec24167253d43a38fb0d0ca2bcbae7b30b477cb2da38030f20c6a42b73bbeac01fa;
endpackage

// File: rtl/rss_cfg_regs.sv
module rss_cfg_regs
  import rss_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int QID_W     = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [1:0]                          sel_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [7:0]                          wdata_i,
  output logic [KEY_W-1:0]                    key_o,
  output logic [TBL_DEPTH-1:0][QID_W-1:0]     tbl_o,
  output logic                                wide_o
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o  <= DEFAULT_KEY;
      wide_o <= 1'b1;
      for (int i = 0; i < TBL_DEPTH; i++) tbl_o[i] <= QID_W'(i % 4);
    end else if (we_i) begin
      case (sel)
        CFG_KEY: begin
          for (int k = 0; k < KEY_BYTES; k++)
            if (addr_i == ADDR_W'(k)) key_o[KEY_W-1-8*k -: 8] <= wdata_i;
        end
        CFG_TBL: begin
          for (int i = 0; i < TBL_DEPTH; i++)
            if (addr_i == ADDR_W'(i)) tbl_o[i] <= wdata_i[QID_W-1:0];
        end
        CFG_SIZE: wide_o <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // R8: a size write must land in the next cycle
  a_r8_size_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd2) |=> (wide_o == $past(wdata_i[0])));
endmodule

// File: rtl/rss_toeplitz_core.sv
module rss_toeplitz_core
  import rss_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              last_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              busy_o,
  output logic [HASH_W-1:0] hash_nxt_o
);
  logic [KEY_W-1:0]  key_sh_q, key_eff;
  logic [HASH_W-1:0] acc_q, acc_eff, contrib;
  logic              busy_q;

  // first byte uses live key and a zero accumulator
  always_comb begin
    key_eff = busy_q ? key_sh_q : key_i;
    acc_eff = busy_q ? acc_q : '0;
    contrib = '0;
    for (int j = 0; j < 8; j++)
      if (data_i[7-j]) contrib = contrib ^ key_eff[KEY_W-1-j -: HASH_W];
  end

  assign hash_nxt_o = acc_eff ^ contrib;
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_sh_q <= '0;
      acc_q    <= '0;
      busy_q   <= 1'b0;
    end else if (valid_i) begin
      key_sh_q <= key_eff << 8;
      acc_q    <= hash_nxt_o;
      busy_q   <= !last_i;
    end
  end

  // R5: last byte always closes the tuple
  a_r5_tuple_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> !busy_o);
  // R4: idle cycles leave the accumulator alone
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i) |=> ($stable(acc_q) && $stable(busy_q)));
endmodule

// File: rtl/rss_queue_sel.sv
module rss_queue_sel
  import rss_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int QID_W     = 4,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic                            busy_i,
  input  logic [TBL_DEPTH-1:0][QID_W-1:0] tbl_i,
  input  logic                            wide_i,
  input  logic [HASH_W-1:0]               hash_i,
  output logic [QID_W-1:0]                qid_o
);
  logic [TBL_DEPTH-1:0][QID_W-1:0] tbl_snap_q, tbl_eff;
  logic                            wide_snap_q, wide_eff;
  logic [IDX_W-1:0]                idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_snap_q  <= '0;
      wide_snap_q <= 1'b1;
    end else if (start_i) begin
      tbl_snap_q  <= tbl_i;
      wide_snap_q <= wide_i;
    end
  end

  always_comb begin
    tbl_eff  = busy_i ? tbl_snap_q : tbl_i;
    wide_eff = busy_i ? wide_snap_q : wide_i;
    idx      = hash_i[IDX_W-1:0];
    if (!wide_eff) idx[IDX_W-1] = 1'b0;
    qid_o    = tbl_eff[idx];
  end

  // R9: snapshot frozen while a tuple is in flight
  a_r9_snap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(tbl_snap_q) && $stable(wide_snap_q)));
endmodule

// File: rtl/rss_hash_top.sv
module rss_hash_top
  import rss_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int QID_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [5:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic              done_o,
  output logic [31:0]       hash_o,
  output logic [QID_W-1:0]  queue_o
);
  logic [KEY_W-1:0]                key_live;
  logic [TBL_DEPTH-1:0][QID_W-1:0] tbl_live;
  logic                            wide_live, busy;
  logic [HASH_W-1:0]               hash_nxt;
  logic [QID_W-1:0]                qid_nxt;

  rss_cfg_regs #(.TBL_DEPTH(TBL_DEPTH), .QID_W(QID_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .key_o(key_live), .tbl_o(tbl_live), .wide_o(wide_live)
  );

  rss_toeplitz_core u_core (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .data_i(in_data_i), .last_i(in_last_i),
    .key_i(key_live), .busy_o(busy), .hash_nxt_o(hash_nxt)
  );

  rss_queue_sel #(.TBL_DEPTH(TBL_DEPTH), .QID_W(QID_W)) u_sel (
    .clk_i, .rst_ni,
    .start_i(in_valid_i && !busy), .busy_i(busy),
    .tbl_i(tbl_live), .wide_i(wide_live), .hash_i(hash_nxt), .qid_o(qid_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      hash_o  <= '0;
      queue_o <= '0;
    end else begin
      done_o <= in_valid_i && in_last_i;
      if (in_valid_i && in_last_i) begin
        hash_o  <= hash_nxt;
        queue_o <= qid_nxt;
      end
    end
  end

  a_r3_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_last_i) |=> done_o);
  a_r3_done_only_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(in_valid_i && in_last_i)) |=> !done_o);
  a_r3_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(in_valid_i && in_last_i)) |=> ($stable(hash_o) && $stable(queue_o)));
endmodule

// File: tb/sim_rss_hash_top.sv
module sim_rss_hash_top;
  localparam int QID_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 0, in_last_i = 0, cfg_we_i = 0;
  logic [7:0] in_data_i = '0, cfg_wdata_i = '0;
  logic [1:0] cfg_sel_i = '0;
  logic [5:0] cfg_addr_i = '0;
  logic done_o;
  logic [31:0] hash_o;
  logic [QID_W-1:0] queue_o;

  rss_hash_top #(.TBL_DEPTH(16), .QID_W(QID_W)) u0 (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [319:0] m_key;
  logic [QID_W-1:0] m_tbl [16];
  logic m_wide;

  localparam logic [95:0] VECS [0:7] = '{
    96'h420995bb_a18e6450_0aea_06e6,
    96'hc75c6f02_41458c53_3796_1283,
    96'h0a000001_0a000002_1f90_0050,
    96'hc0a80164_08080808_c350_0035,
    96'h00000000_00000000_0000_0000,
    96'hffffffff_ffffffff_ffff_ffff,
    96'hac100005_ac10ff01_01bb_e234,
    96'h7f000001_7f000001_0016_0016
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_hash(input logic [287:0] d, input int nb);
    logic [31:0] h = '0;
    for (int i = 0; i < nb * 8; i++)
      if (d[287-i]) h ^= m_key[319-i -: 32];
    return h;
  endfunction

  function automatic logic [QID_W-1:0] m_q(input logic [31:0] h);
    return m_wide ? m_tbl[h[3:0]] : m_tbl[{1'b0, h[2:0]}];
  endfunction

  task automatic m_write(input logic [1:0] s, input logic [5:0] a, input logic [7:0] w);
    if (s == 2'd0) m_key[319-8*a -: 8] = w;
    else if (s == 2'd1) m_tbl[a[3:0]] = w[QID_W-1:0];
    else if (s == 2'd2) m_wide = w[0];
  endtask

  task automatic cfg_wr(input logic [1:0] s, input logic [5:0] a, input logic [7:0] w);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_sel_i = s; cfg_addr_i = a; cfg_wdata_i = w;
    @(negedge clk_i);
    cfg_we_i = 0;
    m_write(s, a, w);
  endtask

  // drive bytes; optional idle gap after each byte; optional config write at byte wr_at
  task automatic send(input logic [287:0] d, input int nb, input int gap,
                      input int wr_at, input logic [1:0] ws, input logic [5:0] wa,
                      input logic [7:0] wd, input string req);
    logic [31:0] eh;
    logic [QID_W-1:0] eq;
    eh = m_hash(d, nb);
    eq = m_q(eh);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk_i);
      in_valid_i = 1; in_data_i = d[287-8*b -: 8]; in_last_i = (b == nb - 1);
      cfg_we_i = (b == wr_at);
      cfg_sel_i = ws; cfg_addr_i = wa; cfg_wdata_i = wd;
      if (b != nb - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk_i);
          in_valid_i = 0; cfg_we_i = 0;
          chk({req, " no early done"}, {31'b0, done_o}, 32'd0);
        end
      end
    end
    @(negedge clk_i);
    in_valid_i = 0; in_last_i = 0; cfg_we_i = 0;
    if (wr_at >= 0) m_write(ws, wa, wd);
    chk({req, " done"}, {31'b0, done_o}, 32'd1);
    chk({req, " hash"}, hash_o, eh);
    chk({req, " queue"}, {28'b0, queue_o}, {28'b0, eq});
    @(negedge clk_i);
    chk({req, " done one cycle (R3)"}, {31'b0, done_o}, 32'd0);
    chk({req, " hash held (R3)"}, hash_o, eh);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed, eh1, eh2;
    int qcnt [4];
    m_key = 320'h6d5a56da255b0ec24167253d43a38fb0d0ca2bcbae7b30b477cb2da38030f20c6a42b73bbeac01fa;
    for (int i = 0; i < 16; i++) m_tbl[i] = QID_W'(i % 4);
    m_wide = 1;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 done", {31'b0, done_o}, 0);
    chk("R1 hash", hash_o, 0);
    chk("R1 queue", {28'b0, queue_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2/R6 with default key and table (R1)
    for (int v = 0; v < 8; v++)
      send({VECS[v], 192'b0}, 12, 0, -1, 0, 0, 0, "R2 R1 R6 vector");

    // R2: determinism
    send({VECS[0], 192'b0}, 12, 0, -1, 0, 0, 0, "R2 repeat");

    // R4: idle gaps inside tuple
    send({VECS[1], 192'b0}, 12, 2, -1, 0, 0, 0, "R4 gaps");

    // R5: one-byte tuple
    send({8'hb7, 280'b0}, 1, 0, -1, 0, 0, 0, "R5 single byte");

    // R5: back-to-back tuples, no idle cycle
    eh1 = m_hash({VECS[2], 192'b0}, 12);
    eh2 = m_hash({VECS[3], 192'b0}, 12);
    for (int b = 0; b < 24; b++) begin
      @(negedge clk_i);
      if (b == 12) begin
        chk("R5 first of pair done", {31'b0, done_o}, 1);
        chk("R5 first of pair hash", hash_o, eh1);
      end
      in_valid_i = 1;
      in_data_i = (b < 12) ? VECS[2][95-8*b -: 8] : VECS[3][95-8*(b-12) -: 8];
      in_last_i = (b == 11) || (b == 23);
    end
    @(negedge clk_i);
    in_valid_i = 0; in_last_i = 0;
    chk("R5 second of pair hash", hash_o, eh2);
    chk("R5 second of pair queue", {28'b0, queue_o}, {28'b0, m_q(eh2)});

    // R7: key write
    cfg_wr(2'd0, 6'd0, 8'h12);
    cfg_wr(2'd0, 6'd39, 8'h5c);
    cfg_wr(2'd0, 6'd5, 8'h00);
    send({VECS[0], 192'b0}, 12, 0, -1, 0, 0, 0, "R7 new key");

    // R8: table writes, then 8-entry mode
    for (int i = 0; i < 16; i++) cfg_wr(2'd1, 6'(i), 8'(15 - i));
    send({VECS[6], 192'b0}, 12, 0, -1, 0, 0, 0, "R8 R6 table 16");
    cfg_wr(2'd2, 6'd0, 8'h00);
    for (int v = 0; v < 4; v++)
      send({VECS[v], 192'b0}, 12, 0, -1, 0, 0, 0, "R8 R6 table 8");
    cfg_wr(2'd2, 6'd0, 8'h01);

    // R9: writes during a tuple apply to the next one
    send({VECS[1], 192'b0}, 12, 0, 4, 2'd0, 6'd1, 8'hff, "R9 key mid");
    send({VECS[1], 192'b0}, 12, 0, -1, 0, 0, 0, "R9 key after");
    eh1 = m_hash({VECS[7], 192'b0}, 12);
    send({VECS[7], 192'b0}, 12, 0, 4, 2'd1, {2'b0, eh1[3:0]}, 8'h09, "R9 table mid");
    send({VECS[7], 192'b0}, 12, 0, -1, 0, 0, 0, "R9 table after");
    send({VECS[5], 192'b0}, 12, 0, 6, 2'd2, 6'd0, 8'h00, "R9 size mid");
    send({VECS[5], 192'b0}, 12, 0, -1, 0, 0, 0, "R9 size after");

    // R6: spread with the default-style table over pseudo-random flows
    cfg_wr(2'd2, 6'd0, 8'h01);
    for (int i = 0; i < 16; i++) cfg_wr(2'd1, 6'(i), 8'(i % 4));
    for (int q = 0; q < 4; q++) qcnt[q] = 0;
    seed = 32'h1234abcd;
    for (int f = 0; f < 64; f++) begin
      logic [95:0] t;
      for (int w = 0; w < 3; w++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        t[95-32*w -: 32] = seed;
      end
      send({t, 192'b0}, 12, 0, -1, 0, 0, 0, "R6 spread");
      qcnt[queue_o[1:0]]++;
    end
    for (int q = 0; q < 4; q++) chk("R6 spread count >= 4", {31'b0, qcnt[q] >= 4}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule